// File: doc/BRIEF.md
# UART Receive/Transmit Interrupt Request Generator

This block derives the two level-sensitive interrupt requests of a UART, one for receive and one for transmit. The UART can run with its FIFOs switched off, leaving single holding registers, or switched on. The block reads the FIFO occupancy counts, the holding-register flags, the data-read and data-write strobes, a pulse marking each fully received character and the baud-rate tick. The FIFOs and the serial shifters are not part of the block.

With the FIFOs off, each request follows its holding register. Receive asks for service while a character waits. Transmit asks for service while the holding register is empty. The strobe that services the register drops the request in the same cycle. With the FIFOs on, receive asks for service at the half-full mark and then keeps asking until the FIFO has been fully drained. It also asks when characters sit in the FIFO but the line has been idle for three character times. Transmit asks for service while the FIFO is less than half full.

Top module: `uart_irq_gen`

## Requirements
- R1: With `fifo_en` low, `rx_irq` one cycle after an edge equals `rx_hold_valid` AND NOT `rd_pulse` sampled at that edge.
- R2: With `fifo_en` low, `tx_irq` one cycle after an edge equals `tx_hold_empty` AND NOT `wr_pulse` sampled at that edge.
- R3: With `fifo_en` low, `rx_level`, `tx_level`, `rx_char_done` and `baud_tick` have no effect on either request.
- R4: With `fifo_en` high, `rx_irq` is high on the cycle after `rx_level` is 8 or more (half of the 16-entry depth). In this mode `rx_hold_valid` and `rd_pulse` do not drop it.
- R5: With `fifo_en` high, once `rx_irq` is set it stays high until `rx_level` is sampled as 0. On the cycle after a 0 level it is low.
- R6: With `fifo_en` high, `tx_irq` is high after any edge where `tx_level` is below 8, and low after any edge where `tx_level` is 8 or more. `tx_hold_empty` and `wr_pulse` have no effect in this mode.
- R7: With `fifo_en` high and `rx_level` nonzero, a timeout sets `rx_irq` when 480 `baud_tick` cycles (3 characters × 10 bits × 16 ticks) pass without a restart. The request is high after the 480th such tick edge and low after the 479th.
- R8: The timeout count restarts on `rx_char_done` or `rd_pulse`. It advances only on cycles where `baud_tick` is high.
- R9: An expired timeout holds `rx_irq` high, through `rd_pulse`, until `rx_level` is 0.
- R10: Any change of `fifo_en` clears the timeout condition and restarts its count.
- R11: While `rst_n` is low, both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 selects FIFO mode, 0 selects holding-register mode |
| rx_level | input | 5 | Receive FIFO occupancy, 0 to 16 |
| tx_level | input | 5 | Transmit FIFO occupancy, 0 to 16 |
| rx_hold_valid | input | 1 | Receive holding register has a character |
| tx_hold_empty | input | 1 | Transmit holding register is empty |
| rd_pulse | input | 1 | Single-cycle read of the receive data |
| wr_pulse | input | 1 | Single-cycle write of the transmit data |
| rx_char_done | input | 1 | Single-cycle pulse for each received character |
| baud_tick | input | 1 | Baud-rate oversampling strobe |
| rx_irq | output | 1 | Receive interrupt request (level) |
| tx_irq | output | 1 | Transmit interrupt request (level) |

## Verification
The bench steps both levels across the 8-entry threshold, from 7 to 8 and back. A design with an off-by-one threshold would raise or drop a request one entry early. It lowers the receive level below half but keeps it nonzero, and checks that the receive request stays up. A design without that hold would drop the request before the FIFO is empty. The timeout is probed at tick 479 and tick 480 after a restart, and again after a read in mid-count. A counter that failed to restart on reads would fire early. After an expired timeout the bench toggles the mode and checks that the request does not come back, which exposes a timeout flag left stale across the mode change.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Baud ticks that make up one character on the line.
  function automatic int unsigned char_ticks(input int unsigned bits_per_char,
                                             input int unsigned ticks_per_bit);
    return bits_per_char * ticks_per_bit;
  endfunction

  // Idle ticks before a receive timeout is declared.
  function automatic int unsigned idle_limit(input int unsigned chars,
                                             input int unsigned bits_per_char,
                                             input int unsigned ticks_per_bit);
    return chars * char_ticks(bits_per_char, ticks_per_bit);
  endfunction

  // Width of a counter that holds 0 .. n-1 (at least 1 bit).
  function automatic int unsigned count_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
  import uart_irq_pkg::*;
#(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned LIMIT = 480,
  parameter int unsigned CNT_W = count_width(LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             mode_chg,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_char_done,
  input  logic             rd_pulse,
  input  logic             baud_tick,
  output logic             to_hit,
  output logic             to_live,
  output logic             to_flag,
  output logic [CNT_W-1:0] to_cnt
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic drain_clr;   // conditions that also drop the expired flag
  logic restart;     // conditions that zero the count

  assign drain_clr = mode_chg | ~fifo_en | (rx_level == '0);
  assign restart   = drain_clr | rx_char_done | rd_pulse;
  assign to_hit    = ~restart & ~to_flag & baud_tick & (to_cnt == LAST);
  assign to_live   = to_hit | (to_flag & ~drain_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      to_cnt  <= '0;
      to_flag <= 1'b0;
    end else if (restart) begin
      to_cnt <= '0;
      if (drain_clr) to_flag <= 1'b0;
    end else if (!to_flag && baud_tick) begin
      if (to_cnt == LAST) begin
        to_cnt  <= '0;
        to_flag <= 1'b1;
      end else begin
        to_cnt <= to_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_rx_req.sv
module uart_rx_req #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned HALF  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             mode_chg,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             rx_hold_valid,
  input  logic             rd_pulse,
  input  logic             to_live,
  output logic             rx_half,
  output logic             rx_irq
);

  localparam logic [LVL_W-1:0] HALF_L = LVL_W'(HALF);

  logic keep;
  logic req_d;

  assign rx_half = (rx_level >= HALF_L);
  assign keep    = rx_irq & ~mode_chg;

  always_comb begin
    if (fifo_en) req_d = (rx_level != '0) & (keep | rx_half | to_live);
    else         req_d = rx_hold_valid & ~rd_pulse;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rx_irq <= 1'b0;
    else        rx_irq <= req_d;
  end

endmodule

// File: rtl/uart_tx_req.sv
module uart_tx_req #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned HALF  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_hold_empty,
  input  logic             wr_pulse,
  output logic             tx_low,
  output logic             tx_irq
);

  localparam logic [LVL_W-1:0] HALF_L = LVL_W'(HALF);

  logic req_d;

  assign tx_low = (tx_level < HALF_L);

  always_comb begin
    if (fifo_en) req_d = tx_low;
    else         req_d = tx_hold_empty & ~wr_pulse;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tx_irq <= 1'b0;
    else        tx_irq <= req_d;
  end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen
  import uart_irq_pkg::*;
#(
  parameter int unsigned DEPTH         = 16,
  parameter int unsigned BITS_PER_CHAR = 10,
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned IDLE_CHARS    = 3,
  localparam int unsigned LVL_W        = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             rx_hold_valid,
  input  logic             tx_hold_empty,
  input  logic             rd_pulse,
  input  logic             wr_pulse,
  input  logic             rx_char_done,
  input  logic             baud_tick,
  output logic             rx_irq,
  output logic             tx_irq
);

  localparam int unsigned HALF  = DEPTH / 2;
  localparam int unsigned LIMIT = idle_limit(IDLE_CHARS, BITS_PER_CHAR, TICKS_PER_BIT);
  localparam int unsigned CNT_W = count_width(LIMIT);

  logic             fifo_en_q;
  logic             mode_chg;
  logic             to_hit;
  logic             to_live;
  logic             to_flag;
  logic [CNT_W-1:0] to_cnt;
  logic             rx_half;
  logic             tx_low;

  always_ff @(posedge clk) begin
    if (!rst_n) fifo_en_q <= 1'b0;
    else        fifo_en_q <= fifo_en;
  end

  assign mode_chg = fifo_en ^ fifo_en_q;

  uart_rx_timeout #(.LVL_W(LVL_W), .LIMIT(LIMIT), .CNT_W(CNT_W)) i_timeout (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_en      (fifo_en),
    .mode_chg     (mode_chg),
    .rx_level     (rx_level),
    .rx_char_done (rx_char_done),
    .rd_pulse     (rd_pulse),
    .baud_tick    (baud_tick),
    .to_hit       (to_hit),
    .to_live      (to_live),
    .to_flag      (to_flag),
    .to_cnt       (to_cnt)
  );

  uart_rx_req #(.LVL_W(LVL_W), .HALF(HALF)) i_rx_req (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_en       (fifo_en),
    .mode_chg      (mode_chg),
    .rx_level      (rx_level),
    .rx_hold_valid (rx_hold_valid),
    .rd_pulse      (rd_pulse),
    .to_live       (to_live),
    .rx_half       (rx_half),
    .rx_irq        (rx_irq)
  );

  uart_tx_req #(.LVL_W(LVL_W), .HALF(HALF)) i_tx_req (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_en       (fifo_en),
    .tx_level      (tx_level),
    .tx_hold_empty (tx_hold_empty),
    .wr_pulse      (wr_pulse),
    .tx_low        (tx_low),
    .tx_irq        (tx_irq)
  );

endmodule

// File: rtl/uart_irq_gen_chk.sv
module uart_irq_gen_chk #(
  parameter int unsigned LVL_W = 5,
  parameter int unsigned CNT_W = 9,
  parameter int unsigned HALF  = 8,
  parameter int unsigned LIMIT = 480
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic [LVL_W-1:0] rx_level,
  input logic [LVL_W-1:0] tx_level,
  input logic             rx_hold_valid,
  input logic             tx_hold_empty,
  input logic             rd_pulse,
  input logic             wr_pulse,
  input logic             rx_irq,
  input logic             tx_irq,
  input logic             mode_chg,
  input logic             to_hit,
  input logic             to_flag,
  input logic [CNT_W-1:0] to_cnt
);

  a_r1_nf_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rx_hold_valid && !rd_pulse) |=> rx_irq);

  a_r1_nf_rx_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && rd_pulse) |=> !rx_irq);

  a_r2_nf_tx_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && wr_pulse) |=> !tx_irq);

  a_r4_rx_half: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_level >= LVL_W'(HALF)) |=> rx_irq);

  a_r5_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && !mode_chg && rx_irq && rx_level != '0) |=> rx_irq);

  a_r5_rx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_level == '0) |=> !rx_irq);

  a_r6_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && tx_level >= LVL_W'(HALF)) |=> !tx_irq);

  a_r7_timeout_req: assert property (@(posedge clk) disable iff (!rst_n)
    to_hit |=> rx_irq);

  a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (to_flag && fifo_en && !mode_chg && rx_level != '0) |=> to_flag);

  a_r10_mode_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !to_flag);

  always_comb begin
    if (rst_n) a_r8_cnt_range: assert (to_cnt < CNT_W'(LIMIT));
  end

endmodule

bind uart_irq_gen uart_irq_gen_chk #(
  .LVL_W(LVL_W), .CNT_W(CNT_W), .HALF(HALF), .LIMIT(LIMIT)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fifo_en       (fifo_en),
  .rx_level      (rx_level),
  .tx_level      (tx_level),
  .rx_hold_valid (rx_hold_valid),
  .tx_hold_empty (tx_hold_empty),
  .rd_pulse      (rd_pulse),
  .wr_pulse      (wr_pulse),
  .rx_irq        (rx_irq),
  .tx_irq        (tx_irq),
  .mode_chg      (mode_chg),
  .to_hit        (to_hit),
  .to_flag       (to_flag),
  .to_cnt        (to_cnt)
);

// File: tb/test_uart_irq_gen.sv
module test_uart_irq_gen;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE_TICKS = 3 * 10 * 16;   // restated from R7

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fifo_en;
  logic [4:0] rx_level;
  logic [4:0] tx_level;
  logic       rx_hold_valid;
  logic       tx_hold_empty;
  logic       rd_pulse;
  logic       wr_pulse;
  logic       rx_char_done;
  logic       baud_tick;
  logic       rx_irq;
  logic       tx_irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_irq_gen i_uart_irq_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .fifo_en       (fifo_en),
    .rx_level      (rx_level),
    .tx_level      (tx_level),
    .rx_hold_valid (rx_hold_valid),
    .tx_hold_empty (tx_hold_empty),
    .rd_pulse      (rd_pulse),
    .wr_pulse      (wr_pulse),
    .rx_char_done  (rx_char_done),
    .baud_tick     (baud_tick),
    .rx_irq        (rx_irq),
    .tx_irq        (tx_irq)
  );

  typedef struct packed {
    logic       fe;
    logic [4:0] rxl;
    logic [4:0] txl;
    logic       hv;
    logic       te;
    logic       rd;
    logic       wr;
    logic       erx;
    logic       etx;
  } vec_t;

  // fe, rx_level, tx_level, hold_valid, tx_empty, rd, wr, exp_rx, exp_tx
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 5'd0,  5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 R2 idle
    '{1'b0, 5'd0,  5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R1 valid
    '{1'b0, 5'd0,  5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 read drops
    '{1'b0, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 empty
    '{1'b0, 5'd0,  5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 write drops
    '{1'b0, 5'd12, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 levels ignored
    '{1'b1, 5'd0,  5'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 above half
    '{1'b1, 5'd7,  5'd8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 R6 boundary
    '{1'b1, 5'd8,  5'd7,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 R6 crossing
    '{1'b1, 5'd3,  5'd7,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 held
    '{1'b1, 5'd1,  5'd12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 R6 hold flags ignored
    '{1'b1, 5'd0,  5'd12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R5 drained
    '{1'b1, 5'd16, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}, // R4 full
    '{1'b1, 5'd16, 5'd16, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R4 R6 strobes ignored
    '{1'b0, 5'd16, 5'd16, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R3 back to hold mode
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      rd_pulse     = 1'b0;
      wr_pulse     = 1'b0;
      rx_char_done = 1'b0;
    end
  endtask

  task automatic restart_char();
    rx_char_done = 1'b1;
    step(1);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b0; rx_level = '0; tx_level = '0;
    rx_hold_valid = 1'b1; tx_hold_empty = 1'b1;
    rd_pulse = 1'b0; wr_pulse = 1'b0; rx_char_done = 1'b0; baud_tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 rx in reset", rx_irq, 1'b0);
    check("R11 tx in reset", tx_irq, 1'b0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      fifo_en = VECS[v].fe; rx_level = VECS[v].rxl; tx_level = VECS[v].txl;
      rx_hold_valid = VECS[v].hv; tx_hold_empty = VECS[v].te;
      rd_pulse = VECS[v].rd; wr_pulse = VECS[v].wr;
      step(1);
      check($sformatf("vector %0d rx", v), rx_irq, VECS[v].erx);
      check($sformatf("vector %0d tx", v), tx_irq, VECS[v].etx);
    end

    // R3: ticks and character pulses have no effect in hold mode
    fifo_en = 1'b0; rx_level = 5'd3; tx_level = 5'd0;
    rx_hold_valid = 1'b0; tx_hold_empty = 1'b0; baud_tick = 1'b1;
    restart_char();
    step(IDLE_TICKS + 20);
    check("R3 no timeout in hold mode", rx_irq, 1'b0);
    check("R3 tx unaffected", tx_irq, 1'b0);

    // R7: timeout exactly at tick 480 after a restart
    fifo_en = 1'b1; baud_tick = 1'b0; tx_level = 5'd16;
    step(1);
    check("R10 mode entry no stale req", rx_irq, 1'b0);
    baud_tick = 1'b1;
    restart_char();
    step(IDLE_TICKS - 1);
    check("R7 tick 479", rx_irq, 1'b0);
    step(1);
    check("R7 tick 480", rx_irq, 1'b1);

    // R9: read does not clear; only draining does
    rd_pulse = 1'b1;
    step(1);
    check("R9 read keeps timeout req", rx_irq, 1'b1);
    step(10);
    check("R9 held while nonempty", rx_irq, 1'b1);
    rx_level = 5'd0;
    step(1);
    check("R9 cleared on empty", rx_irq, 1'b0);

    // R10: mode toggle discards an expired timeout
    rx_level = 5'd3;
    restart_char();
    step(IDLE_TICKS);
    check("R10 setup timeout", rx_irq, 1'b1);
    fifo_en = 1'b0;
    step(1);
    fifo_en = 1'b1;
    step(1);
    check("R10 timeout gone after toggle", rx_irq, 1'b0);

    // R8: a read mid-count restarts the count
    restart_char();
    step(300);
    rd_pulse = 1'b1;
    step(1);
    step(IDLE_TICKS - 1);
    check("R8 read restarted count", rx_irq, 1'b0);
    step(1);
    check("R8 fires after full window", rx_irq, 1'b1);
    rx_level = 5'd0;
    step(1);

    // R8: no baud ticks, no progress
    rx_level = 5'd3; baud_tick = 1'b0;
    restart_char();
    step(IDLE_TICKS + 120);
    check("R8 no ticks no timeout", rx_irq, 1'b0);

    finish_run();
  end

endmodule